// File: doc/BRIEF.md
# Multi-Size Condition Code Evaluator

This block turns the saved operands of a finished operation into condition flags and merges them into a status register. The caller presents the operation class, the operand size (byte, halfword or word), the source, destination and result values, the high word of a multiply and the extended-arithmetic indication. Alongside these comes a mask naming the flags the operation may touch. The evaluation is combinational. The merged status is registered and appears one clock after a cycle with `op_valid` high.

The flags come from the operand and result sign bits at the chosen size, not from a carry chain. Subtract and compare invert the source first and then toggle the carry. Multiplies judge the 64-bit product. A bit-test class updates only the negative and zero flags. A "flags already live" class leaves the register alone. Flag positions are parameters and default to C=0, V=1, Z=2, N=3, X=4, R=5.

Top module: `ccr_eval_unit`

## Requirements
- R1: After reset, `status` is all zeros.
- R2: For add-like classes at size code 0/1/2 (sign bit 7, 15 or 31; code 3 acts as 2), a negative result sets N, plus V when both operand signs are 0, else C when both are 1. A non-negative result sets Z when the sized result is zero, V when both operand signs are 1, and C when either is 1. ADD is class code 0.
- R3: SUB (code 1) and CMP (code 2) evaluate with the source bitwise inverted, then invert the computed C.
- R4: MOVE/logic/shift (code 3) computes only N and Z at the size. N is the result sign, and Z is set only for a non-negative, zero sized result. V and C are computed as 0.
- R5: Signed multiply (code 4) uses {hi, result}: Z when zero, N when bit 63 is 1, and V when hi differs from the sign extension of result bit 31.
- R6: Unsigned multiply (code 5) uses {hi, result}: Z when zero, N when bit 63 is 1, and V when hi is nonzero.
- R7: MCP (code 6) follows the add-like rule but writes the carry result to R (bit 5) instead of C.
- R8: Writeback uses upd_mask plus X. Those bits take the new flags (X becomes 0), and every other bit keeps its value.
- R9: When ext_x is 1 and the new Z is 1, Z leaves the writeback mask and keeps its old value. A new Z of 0 still clears it.
- R10: Bit test (code 7) takes the index from src[4:0] and the value from dst. N (bit 3) is set to the selected bit. Z (bit 2) is set when that bit and all lower bits are 0. X is cleared and the other bits are unchanged, whatever upd_mask holds.
- R11: The live class (code 8) and any cycle with op_valid low leave `status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Apply an update at this edge |
| op_class | input | 4 | Operation class code |
| op_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| op_src | input | 32 | Saved source operand (bit index for bit test) |
| op_dst | input | 32 | Saved destination operand |
| op_res | input | 32 | Saved result (low word for multiplies) |
| op_hi | input | 32 | Multiply high word |
| ext_x | input | 1 | X flag as it stood before the operation |
| upd_mask | input | 8 | Flags the operation may update |
| status | output | 8 | Registered status register |

## Verification
The add-like rule is tried at all three sizes with the sign bit of interest sitting above garbage-free and wrapping sums, so the byte and halfword lanes are told apart from the full word. Borrow and no-borrow subtracts and an equal compare separate the inverted source and C toggle from the plain add. Multiply products with high word zero, all ones and top bit set distinguish the signed and unsigned overflow rules. Partial masks, extended mode with zero and non-zero results, bit indices 0, 3, 4 and 31, and the live class each show which bits move and which hold.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMP  = 4'd2,
        OP_MOVE = 4'd3,
        OP_MULS = 4'd4,
        OP_MULU = 4'd5,
        OP_MCP  = 4'd6,
        OP_BTST = 4'd7,
        OP_LIVE = 4'd8
    } op_class_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } op_size_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

endpackage

// File: rtl/ccr_sign_eval.sv
module ccr_sign_eval
    import ccr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [1:0]    size,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] res,
    output nzvc_t         flags,
    output logic          res_neg,
    output logic          res_zero
);
    localparam int LANES = DW / 8;

    logic [LANES-1:0] lane_zero;
    logic             s_src;
    logic             s_dst;
    int               sb;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign lane_zero[g] = (res[g*8 +: 8] == 8'd0);
        end
    endgenerate

    always_comb begin
        unique case (op_size_e'(size))
            SZ_BYTE: begin sb = 7;      res_zero = lane_zero[0];   end
            SZ_HALF: begin sb = 15;     res_zero = &lane_zero[1:0]; end
            default: begin sb = DW - 1; res_zero = &lane_zero;     end
        endcase
        s_src   = src[sb];
        s_dst   = dst[sb];
        res_neg = res[sb];
        flags   = '0;
        if (res_neg) begin
            flags.n = 1'b1;
            flags.v = !s_src && !s_dst;
            flags.c = s_src && s_dst;
        end else begin
            flags.z = res_zero;
            flags.v = s_src && s_dst;
            flags.c = s_src || s_dst;
        end
    end

endmodule

// File: rtl/ccr_mul_eval.sv
module ccr_mul_eval
    import ccr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          signed_mode,
    input  logic [DW-1:0] hi,
    input  logic [DW-1:0] lo,
    output nzvc_t         flags
);
    logic [2*DW-1:0] wide;

    always_comb begin
        wide    = {hi, lo};
        flags   = '0;
        flags.z = (wide == '0);
        flags.n = wide[2*DW-1];
        if (signed_mode) flags.v = (hi != {DW{lo[DW-1]}});
        else             flags.v = (hi != '0);
    end

endmodule

// File: rtl/ccr_btst_eval.sv
module ccr_btst_eval #(
    parameter int DW = 32,
    localparam int IW = $clog2(DW)
) (
    input  logic [DW-1:0] val,
    input  logic [IW-1:0] sel,
    output logic          bit_n,
    output logic          bit_z
);
    logic [DW-1:0] at_or_below;

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            at_or_below[i] = (i <= int'(sel));
        end
        bit_n = val[sel];
        bit_z = ((val & at_or_below) == '0);
    end

endmodule

// File: rtl/ccr_eval_unit.sv
module ccr_eval_unit
    import ccr_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int SR_W  = 8,
    parameter int C_POS = 0,
    parameter int V_POS = 1,
    parameter int Z_POS = 2,
    parameter int N_POS = 3,
    parameter int X_POS = 4,
    parameter int R_POS = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [3:0]      op_class,
    input  logic [1:0]      op_size,
    input  logic [DW-1:0]   op_src,
    input  logic [DW-1:0]   op_dst,
    input  logic [DW-1:0]   op_res,
    input  logic [DW-1:0]   op_hi,
    input  logic            ext_x,
    input  logic [SR_W-1:0] upd_mask,
    output logic [SR_W-1:0] status
);
    localparam int IW = $clog2(DW);
    localparam logic [SR_W-1:0] ONE   = 1;
    localparam logic [SR_W-1:0] X_BIT = ONE << X_POS;
    localparam logic [SR_W-1:0] BT_BITS = (ONE << X_POS) | (ONE << N_POS) | (ONE << Z_POS);

    op_class_e       cls;
    logic [DW-1:0]   src_eff;
    nzvc_t           add_f;
    nzvc_t           mul_f;
    logic            res_neg;
    logic            res_zero;
    logic            bt_n;
    logic            bt_z;
    logic [SR_W-1:0] new_fl;
    logic [SR_W-1:0] wmask;
    logic [SR_W-1:0] status_nx;

    assign cls     = op_class_e'(op_class);
    assign src_eff = (cls == OP_SUB || cls == OP_CMP) ? ~op_src : op_src;

    ccr_sign_eval #(.DW(DW)) u_sign (
        .size     (op_size),
        .src      (src_eff),
        .dst      (op_dst),
        .res      (op_res),
        .flags    (add_f),
        .res_neg  (res_neg),
        .res_zero (res_zero)
    );

    ccr_mul_eval #(.DW(DW)) u_mul (
        .signed_mode (cls == OP_MULS),
        .hi          (op_hi),
        .lo          (op_res),
        .flags       (mul_f)
    );

    ccr_btst_eval #(.DW(DW)) u_btst (
        .val   (op_dst),
        .sel   (op_src[IW-1:0]),
        .bit_n (bt_n),
        .bit_z (bt_z)
    );

    // Flag vector for the selected class
    always_comb begin
        new_fl = '0;
        unique case (cls)
            OP_ADD: begin
                new_fl[N_POS] = add_f.n; new_fl[Z_POS] = add_f.z;
                new_fl[V_POS] = add_f.v; new_fl[C_POS] = add_f.c;
            end
            OP_SUB, OP_CMP: begin
                new_fl[N_POS] = add_f.n;  new_fl[Z_POS] = add_f.z;
                new_fl[V_POS] = add_f.v;  new_fl[C_POS] = !add_f.c;
            end
            OP_MOVE: begin
                new_fl[N_POS] = res_neg;
                new_fl[Z_POS] = !res_neg && res_zero;
            end
            OP_MULS, OP_MULU: begin
                new_fl[N_POS] = mul_f.n; new_fl[Z_POS] = mul_f.z;
                new_fl[V_POS] = mul_f.v;
            end
            OP_MCP: begin
                new_fl[N_POS] = add_f.n; new_fl[Z_POS] = add_f.z;
                new_fl[V_POS] = add_f.v; new_fl[R_POS] = add_f.c;
            end
            default: new_fl = '0;
        endcase
    end

    // Writeback merge
    always_comb begin
        wmask = upd_mask | X_BIT;
        if (ext_x && new_fl[Z_POS]) wmask[Z_POS] = 1'b0;
        status_nx = status;
        if (op_valid) begin
            if (cls == OP_BTST) begin
                status_nx[X_POS] = 1'b0;
                status_nx[N_POS] = bt_n;
                status_nx[Z_POS] = bt_z;
            end else if (cls != OP_LIVE) begin
                status_nx = (status & ~wmask) | (new_fl & wmask);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= status_nx;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || cls == OP_LIVE) |=> $stable(status)); // R11

    AST_X_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cls != OP_LIVE) |=> !status[X_POS]); // R8

    AST_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cls != OP_LIVE && cls != OP_BTST)
        |=> ((status ^ $past(status)) & ~($past(upd_mask) | X_BIT)) == '0); // R8

    AST_EXT_Z_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cls != OP_LIVE && cls != OP_BTST && ext_x && new_fl[Z_POS])
        |=> status[Z_POS] == $past(status[Z_POS])); // R9

    AST_BTST_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cls == OP_BTST)
        |=> ((status ^ $past(status)) & ~BT_BITS) == '0); // R10

    AST_MULU_V: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cls == OP_MULU && upd_mask[V_POS])
        |=> status[V_POS] == ($past(op_hi) != '0)); // R6

    AST_ADD_WORD_N: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cls == OP_ADD && op_size == 2'd2 && upd_mask[N_POS])
        |=> status[N_POS] == $past(op_res[DW-1])); // R2

endmodule

// File: tb/sim_ccr_eval_unit.sv
module sim_ccr_eval_unit;
    import ccr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 19;

    typedef struct packed {
        logic [3:0]  cls;
        logic [1:0]  size;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] res;
        logic [31:0] hi;
        logic [7:0]  exp;
    } vec_t;

    // All with mask 0x0F, ext_x 0: expected = {N,Z,V,C} in bits 3..0
    localparam vec_t VECS [NV] = '{
        '{OP_ADD,  2'd0, 32'h7F,       32'h01,       32'h80,       32'h0,        8'h0A}, // R2
        '{OP_ADD,  2'd0, 32'h80,       32'h80,       32'h100,      32'h0,        8'h07}, // R2
        '{OP_ADD,  2'd1, 32'hFFFF,     32'h0001,     32'h10000,    32'h0,        8'h05}, // R2
        '{OP_ADD,  2'd2, 32'h80000000, 32'h80000001, 32'h00000001, 32'h0,        8'h03}, // R2
        '{OP_ADD,  2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h0,        8'h09}, // R2
        '{OP_ADD,  2'd2, 32'h1,        32'h2,        32'h3,        32'h0,        8'h00}, // R2
        '{OP_SUB,  2'd2, 32'h3,        32'h5,        32'h2,        32'h0,        8'h00}, // R3
        '{OP_SUB,  2'd2, 32'h5,        32'h3,        32'hFFFFFFFE, 32'h0,        8'h09}, // R3
        '{OP_CMP,  2'd0, 32'h10,       32'h10,       32'h0,        32'h0,        8'h04}, // R3
        '{OP_SUB,  2'd1, 32'h0001,     32'h8000,     32'h7FFF,     32'h0,        8'h02}, // R3
        '{OP_MOVE, 2'd0, 32'h0,        32'h0,        32'h80,       32'h0,        8'h08}, // R4
        '{OP_MOVE, 2'd1, 32'h0,        32'h0,        32'hFFFF0000, 32'h0,        8'h04}, // R4
        '{OP_MOVE, 2'd0, 32'h0,        32'h0,        32'h100,      32'h0,        8'h04}, // R4
        '{OP_MOVE, 2'd2, 32'h0,        32'h0,        32'h80000000, 32'h0,        8'h08}, // R4
        '{OP_MULS, 2'd2, 32'h0,        32'h0,        32'h80000000, 32'hFFFFFFFF, 8'h08}, // R5
        '{OP_MULS, 2'd2, 32'h0,        32'h0,        32'h80000000, 32'h0,        8'h02}, // R5
        '{OP_MULS, 2'd2, 32'h0,        32'h0,        32'h0,        32'h0,        8'h04}, // R5
        '{OP_MULU, 2'd2, 32'h0,        32'h0,        32'h0,        32'h80000000, 8'h0A}, // R6
        '{OP_MULU, 2'd2, 32'h0,        32'h0,        32'hFFFFFFFF, 32'h0,        8'h00}  // R6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_class = '0;
    logic [1:0]  op_size = '0;
    logic [31:0] op_src = '0, op_dst = '0, op_res = '0, op_hi = '0;
    logic        ext_x = 1'b0;
    logic [7:0]  upd_mask = '0;
    logic [7:0]  status;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccr_eval_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .op_size(op_size), .op_src(op_src), .op_dst(op_dst), .op_res(op_res),
        .op_hi(op_hi), .ext_x(ext_x), .upd_mask(upd_mask), .status(status)
    );

    task automatic apply(input logic vld, input logic [3:0] c, input logic [1:0] s,
                         input logic [31:0] sr, input logic [31:0] d, input logic [31:0] r,
                         input logic [31:0] h, input logic [7:0] m, input logic e);
        @(negedge clk);
        op_valid = vld; op_class = c; op_size = s; op_src = sr; op_dst = d;
        op_res = r; op_hi = h; upd_mask = m; ext_x = e;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic check(input string tag, input logic [7:0] exp);
        n_tests++;
        if (status !== exp) begin
            n_fail++;
            $display("FAIL %s: status=%02h expected=%02h", tag, status, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 8'h00);

        for (int i = 0; i < NV; i++) begin
            apply(1'b1, VECS[i].cls, VECS[i].size, VECS[i].src, VECS[i].dst,
                  VECS[i].res, VECS[i].hi, 8'h0F, 1'b0);
            check($sformatf("R2-6 vector %0d", i), VECS[i].exp);
        end

        // R7: MCP writes R (bit 5) in place of C
        apply(1'b1, OP_MCP, 2'd2, 32'h80000000, 32'h80000000, 32'h0, 32'h0, 8'h2E, 1'b0);
        check("R7 mcp zero", 8'h26);
        apply(1'b1, OP_MCP, 2'd2, 32'h80000000, 32'h80000000, 32'h80000000, 32'h0, 8'h2E, 1'b0);
        check("R7 mcp negative", 8'h28);

        // R8: only masked bits change
        apply(1'b1, OP_ADD, 2'd2, 32'h1, 32'h2, 32'h3, 32'h0, 8'h08, 1'b0);
        check("R8 partial mask", 8'h20);

        // R9: extended mode keeps Z when the new Z is 1
        apply(1'b1, OP_ADD, 2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 8'h0F, 1'b1);
        check("R9 ext keep clear Z", 8'h20);
        apply(1'b1, OP_ADD, 2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 8'h0F, 1'b0);
        check("R9 normal sets Z", 8'h24);
        apply(1'b1, OP_ADD, 2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 8'h0F, 1'b1);
        check("R9 ext keep set Z", 8'h24);
        apply(1'b1, OP_ADD, 2'd2, 32'h0, 32'h1, 32'h1, 32'h0, 8'h0F, 1'b1);
        check("R9 ext clears Z", 8'h20);

        // R10: bit test
        apply(1'b1, OP_ADD, 2'd2, 32'h80000000, 32'h80000001, 32'h1, 32'h0, 8'h0F, 1'b0);
        check("R2 set V and C", 8'h23);
        apply(1'b1, OP_BTST, 2'd2, 32'h4, 32'h10, 32'h0, 32'h0, 8'h00, 1'b0);
        check("R10 bit 4 set", 8'h2B);
        apply(1'b1, OP_BTST, 2'd2, 32'h23, 32'h10, 32'h0, 32'h0, 8'hFF, 1'b0);
        check("R10 bit 3 low zero", 8'h27);
        apply(1'b1, OP_BTST, 2'd2, 32'h1F, 32'h80000000, 32'h0, 32'h0, 8'h00, 1'b0);
        check("R10 bit 31", 8'h2B);
        apply(1'b1, OP_BTST, 2'd2, 32'h0, 32'hFFFFFFFE, 32'h0, 32'h0, 8'h00, 1'b0);
        check("R10 bit 0", 8'h27);

        // R11: live class and idle cycles
        apply(1'b1, OP_LIVE, 2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 8'hFF, 1'b0);
        check("R11 live class", 8'h27);
        apply(1'b0, OP_ADD, 2'd2, 32'h1, 32'h2, 32'h3, 32'h0, 8'hFF, 1'b0);
        check("R11 valid low", 8'h27);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule